// File: doc/BRIEF.md
# Trap and Coprocessor-0 Control Unit

This unit decides, one cycle at a time, whether a five-stage pipeline must leave its normal instruction flow. Each pipeline stage can present a fault request. The request carries a five-bit fault code, the instruction's PC and a flag that marks the instruction as sitting in a branch delay slot. The unit also watches a small set of external interrupt lines, one of which is the timer. It watches a return-from-trap strobe as well. In the same cycle it drives a per-stage kill mask, a redirect enable and a fetch target. The target is either the fixed handler entry or, on a return, the saved exception PC.

The unit owns three coprocessor-0 registers: status, cause and exception PC. Software reads them combinationally through a five-bit select and writes them on the next clock edge. Stage index 0 holds the oldest instruction and higher indices hold younger ones. The return instruction and handler entry both redirect without a delay slot. The kill mask therefore squashes every younger stage, so nothing after the redirect point executes.

Top module: `trap_unit`

## Requirements
- R1: After reset, status, cause and exception PC all read as zero, and no redirect or kill is signalled while no request is present.
- R2: An exception request redirects fetch to 0x00004180 in the same cycle. On the next edge, cause bits 6:2 take the request's code: 4 for a fetch/load address fault, 5 for a store address fault, 10 for a reserved opcode, 12 for overflow.
- R3: On a trap taken while status bit 1 (exception level) is clear, the exception PC becomes the instruction's PC and cause bit 31 is cleared. If the instruction's delay-slot flag is set, the exception PC becomes PC-4 and cause bit 31 is set.
- R4: Among simultaneous exception requests the lowest stage index wins. Its PC and code are recorded, and the kill mask sets that stage and every higher index.
- R5: An interrupt is taken only when status bit 0 is set, status bit 1 is clear, and for some line k both the line and status bit 10+k are set. The trap records code 0 and the PC and delay-slot flag of stage 0, and it kills all stages.
- R6: An exception request in any stage takes precedence over an interrupt that is pending and enabled in the same cycle.
- R7: Taking a trap sets status bit 1. A return strobe clears it, redirects to the saved exception PC, and kills every stage except stage 0.
- R8: Cause bits 10+k show interrupt line k as sampled on the previous clock edge, whatever the enable and mask settings.
- R9: A write selects status (12), cause (13) or exception PC (14). Status keeps only bits 0, 1 and 10+k; cause keeps only bits 31 and 6:2. Reads of any other select return zero, and a trap in the same cycle overrides a register write.
- R10: A return strobe takes precedence over exception requests and interrupts in the same cycle.
- R11: A trap taken while status bit 1 is already set still redirects and updates the cause code, but leaves the exception PC and cause bit 31 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | NSTG | Per-stage exception request, index 0 oldest |
| exc_code_i | input | 5*NSTG | Per-stage fault code, stage s at bits 5s+4:5s |
| exc_pc_i | input | 32*NSTG | Per-stage instruction PC, stage s at bits 32s+31:32s |
| exc_bd_i | input | NSTG | Per-stage delay-slot flag |
| irq_i | input | NIRQ | External interrupt lines (timer on line 0) |
| eret_i | input | 1 | Return-from-trap strobe from stage 0 |
| mt_en_i | input | 1 | Register write enable |
| mt_sel_i | input | 5 | Register write select |
| mt_data_i | input | 32 | Register write data |
| mf_sel_i | input | 5 | Register read select |
| mf_data_o | output | 32 | Register read data |
| redirect_o | output | 1 | Fetch redirect enable |
| target_o | output | 32 | Fetch redirect target |
| kill_o | output | NSTG | Per-stage squash mask |

## Verification
The bench builds the unit with three stages and two interrupt lines. With three stages, the oldest-wins choice between two younger requests can be tested, and the kill mask shows both partial and full flushes. With two lines, the bench can mask one line while the other is taken, and it can see both pending bits move independently.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN = 32;

  localparam logic [4:0] SEL_STATUS = 5'd12;
  localparam logic [4:0] SEL_CAUSE  = 5'd13;
  localparam logic [4:0] SEL_EPC    = 5'd14;

  localparam logic [4:0] CODE_INT  = 5'd0;
  localparam logic [4:0] CODE_ADEL = 5'd4;
  localparam logic [4:0] CODE_ADES = 5'd5;
  localparam logic [4:0] CODE_RI   = 5'd10;
  localparam logic [4:0] CODE_OV   = 5'd12;

  localparam int ST_IE       = 0;
  localparam int ST_EXL      = 1;
  localparam int MASK_LSB    = 10;
  localparam int CA_CODE_LSB = 2;
  localparam int CA_BD       = 31;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_EXC,
    ACT_IRQ,
    ACT_RET
  } act_e;
endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int NSTG = 3,
  parameter int IW   = 2
) (
  input  logic [NSTG-1:0] req_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o,
  output logic [NSTG-1:0] tail_o
);
  logic [NSTG-1:0] tail;

  // tail[i] set once any stage at or below i requests
  assign tail[0] = req_i[0];
  for (genvar i = 1; i < NSTG; i++) begin : g_tail
    assign tail[i] = tail[i-1] | req_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o  = tail[NSTG-1];
  assign tail_o = tail;
endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter int NIRQ = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            mt_en_i,
  input  logic [4:0]      mt_sel_i,
  input  logic [XLEN-1:0] mt_data_i,
  input  logic [4:0]      mf_sel_i,
  output logic [XLEN-1:0] mf_data_o,
  input  logic            take_i,
  input  logic            ret_i,
  input  logic [4:0]      code_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic            bd_i,
  output logic            ie_o,
  output logic            exl_o,
  output logic [NIRQ-1:0] im_o,
  output logic [XLEN-1:0] epc_o
);
  logic            ie_q, exl_q, bd_q;
  logic [NIRQ-1:0] im_q, ip_q;
  logic [4:0]      code_q;
  logic [XLEN-1:0] epc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_q <= '0;
    end else begin
      ip_q <= irq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      im_q   <= '0;
      bd_q   <= 1'b0;
      code_q <= '0;
      epc_q  <= '0;
    end else if (take_i) begin
      exl_q  <= 1'b1;
      code_q <= code_i;
      if (!exl_q) begin
        epc_q <= epc_i;
        bd_q  <= bd_i;
      end
    end else if (ret_i) begin
      exl_q <= 1'b0;
    end else if (mt_en_i) begin
      unique case (mt_sel_i)
        SEL_STATUS: begin
          ie_q  <= mt_data_i[ST_IE];
          exl_q <= mt_data_i[ST_EXL];
          im_q  <= mt_data_i[MASK_LSB +: NIRQ];
        end
        SEL_CAUSE: begin
          bd_q   <= mt_data_i[CA_BD];
          code_q <= mt_data_i[CA_CODE_LSB +: 5];
        end
        SEL_EPC: epc_q <= mt_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    mf_data_o = '0;
    unique case (mf_sel_i)
      SEL_STATUS: begin
        mf_data_o[ST_IE]            = ie_q;
        mf_data_o[ST_EXL]           = exl_q;
        mf_data_o[MASK_LSB +: NIRQ] = im_q;
      end
      SEL_CAUSE: begin
        mf_data_o[CA_BD]             = bd_q;
        mf_data_o[MASK_LSB +: NIRQ]  = ip_q;
        mf_data_o[CA_CODE_LSB +: 5]  = code_q;
      end
      SEL_EPC: mf_data_o = epc_q;
      default: ;
    endcase
  end

  assign ie_o  = ie_q;
  assign exl_o = exl_q;
  assign im_o  = im_q;
  assign epc_o = epc_q;

  assert_pending_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ip_q == $past(irq_i));
  assert_epc_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && exl_q) |=> $stable(epc_q) && $stable(bd_q));
  assert_ret_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !take_i) |=> !exl_q);
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int          NSTG    = 3,
  parameter int          NIRQ    = 6,
  parameter logic [31:0] HANDLER = 32'h0000_4180
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NSTG-1:0]      exc_req_i,
  input  logic [5*NSTG-1:0]    exc_code_i,
  input  logic [XLEN*NSTG-1:0] exc_pc_i,
  input  logic [NSTG-1:0]      exc_bd_i,
  input  logic [NIRQ-1:0]      irq_i,
  input  logic                 eret_i,
  input  logic                 mt_en_i,
  input  logic [4:0]           mt_sel_i,
  input  logic [XLEN-1:0]      mt_data_i,
  input  logic [4:0]           mf_sel_i,
  output logic [XLEN-1:0]      mf_data_o,
  output logic                 redirect_o,
  output logic [XLEN-1:0]      target_o,
  output logic [NSTG-1:0]      kill_o
);
  localparam int IW = (NSTG > 1) ? $clog2(NSTG) : 1;

  logic [4:0]      code_a [NSTG];
  logic [XLEN-1:0] pc_a   [NSTG];

  for (genvar s = 0; s < NSTG; s++) begin : g_unpack
    assign code_a[s] = exc_code_i[5*s +: 5];
    assign pc_a[s]   = exc_pc_i[XLEN*s +: XLEN];
  end

  logic            exc_any;
  logic [IW-1:0]   exc_idx;
  logic [NSTG-1:0] exc_tail;

  trap_prio #(.NSTG(NSTG), .IW(IW)) u_prio (
    .req_i  (exc_req_i),
    .any_o  (exc_any),
    .idx_o  (exc_idx),
    .tail_o (exc_tail)
  );

  logic            ie, exl;
  logic [NIRQ-1:0] im;
  logic [XLEN-1:0] epc;
  logic            irq_hit, take;
  act_e            act;
  logic [4:0]      sel_code;
  logic [XLEN-1:0] sel_pc, epc_val;
  logic            sel_bd;

  assign irq_hit = ie && !exl && |(irq_i & im);

  always_comb begin
    if (eret_i)       act = ACT_RET;
    else if (exc_any) act = ACT_EXC;
    else if (irq_hit) act = ACT_IRQ;
    else              act = ACT_NONE;
  end

  assign take = (act == ACT_EXC) || (act == ACT_IRQ);

  always_comb begin
    if (act == ACT_EXC) begin
      sel_code = code_a[exc_idx];
      sel_pc   = pc_a[exc_idx];
      sel_bd   = exc_bd_i[exc_idx];
    end else begin
      sel_code = CODE_INT;
      sel_pc   = pc_a[0];
      sel_bd   = exc_bd_i[0];
    end
  end

  // delay-slot victim resumes at its branch
  assign epc_val = sel_bd ? sel_pc - XLEN'(4) : sel_pc;

  trap_csr #(.NIRQ(NIRQ)) u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .mt_en_i   (mt_en_i),
    .mt_sel_i  (mt_sel_i),
    .mt_data_i (mt_data_i),
    .mf_sel_i  (mf_sel_i),
    .mf_data_o (mf_data_o),
    .take_i    (take),
    .ret_i     (act == ACT_RET),
    .code_i    (sel_code),
    .epc_i     (epc_val),
    .bd_i      (sel_bd),
    .ie_o      (ie),
    .exl_o     (exl),
    .im_o      (im),
    .epc_o     (epc)
  );

  always_comb begin
    unique case (act)
      ACT_RET: kill_o = {{(NSTG-1){1'b1}}, 1'b0};
      ACT_EXC: kill_o = exc_tail;
      ACT_IRQ: kill_o = '1;
      default: kill_o = '0;
    endcase
  end

  assign redirect_o = act != ACT_NONE;
  assign target_o   = (act == ACT_RET) ? epc : HANDLER;

  assert_fixed_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !eret_i) |-> target_o == HANDLER);
  assert_trap_sets_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> exl);
  assert_no_nested_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exl |-> act != ACT_IRQ);
  assert_oldest_kill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_EXC) |-> kill_o[exc_idx] && ($countones(kill_o) == NSTG - int'(exc_idx)));
  assert_ret_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i |-> redirect_o && target_o == epc && !kill_o[0]);
endmodule

// File: tb/sim_trap_unit.sv
module sim_trap_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int NI = 2;
  localparam logic [31:0] H = 32'h0000_4180;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NS-1:0]   exc_req_i = '0;
  logic [5*NS-1:0] exc_code_i = '0;
  logic [32*NS-1:0] exc_pc_i = '0;
  logic [NS-1:0]   exc_bd_i = '0;
  logic [NI-1:0]   irq_i = '0;
  logic            eret_i = 1'b0;
  logic            mt_en_i = 1'b0;
  logic [4:0]      mt_sel_i = '0;
  logic [31:0]     mt_data_i = '0;
  logic [4:0]      mf_sel_i = '0;
  logic [31:0]     mf_data_o;
  logic            redirect_o;
  logic [31:0]     target_o;
  logic [NS-1:0]   kill_o;

  trap_unit #(.NSTG(NS), .NIRQ(NI)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // staged stimulus, applied by step()
  logic [NS-1:0]    s_req = '0;
  logic [5*NS-1:0]  s_code = '0;
  logic [32*NS-1:0] s_pc = '0;
  logic [NS-1:0]    s_bd = '0;
  logic [NI-1:0]    s_irq = '0;
  logic             s_eret = 1'b0;
  logic             s_mt = 1'b0;
  logic [4:0]       s_mts = '0;
  logic [31:0]      s_mtd = '0;
  logic [4:0]       s_mf = '0;

  typedef struct packed {
    logic        redir;
    logic [31:0] tgt;
    logic [2:0]  kill;
    logic [31:0] rd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  task automatic set_exc(int s, logic [4:0] code, logic [31:0] pc, logic bd);
    s_req[s] = 1'b1;
    s_code[5*s +: 5] = code;
    s_pc[32*s +: 32] = pc;
    s_bd[s] = bd;
  endtask

  task automatic step(string tag, logic redir, logic [31:0] tgt, logic [2:0] kill, logic [31:0] rd);
    exp_t e;
    @(posedge clk_i);
    #1;
    exc_req_i = s_req; exc_code_i = s_code; exc_pc_i = s_pc; exc_bd_i = s_bd;
    irq_i = s_irq; eret_i = s_eret; mt_en_i = s_mt; mt_sel_i = s_mts;
    mt_data_i = s_mtd; mf_sel_i = s_mf;
    e.redir = redir; e.tgt = tgt; e.kill = kill; e.rd = rd;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    s_req = '0; s_code = '0; s_pc = '0; s_bd = '0; s_irq = '0;
    s_eret = 1'b0; s_mt = 1'b0; s_mts = '0; s_mtd = '0; s_mf = '0;
  endtask

  task automatic wr(logic [4:0] sel, logic [31:0] d);
    s_mt = 1'b1; s_mts = sel; s_mtd = d;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      bit    bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      bad = (redirect_o !== e.redir) || (kill_o !== e.kill) || (mf_data_o !== e.rd) ||
            (e.redir && (target_o !== e.tgt));
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: redir=%b tgt=%h kill=%b rd=%h expected redir=%b tgt=%h kill=%b rd=%h",
                 t, redirect_o, target_o, kill_o, mf_data_o, e.redir, e.tgt, e.kill, e.rd);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset values
    s_mf = 5'd12; step("R1 status", 0, 0, 3'b000, 32'h0);
    s_mf = 5'd13; step("R1 cause", 0, 0, 3'b000, 32'h0);
    s_mf = 5'd14; step("R1 epc", 0, 0, 3'b000, 32'h0);
    // R9 register access
    wr(5'd12, 32'h8000_0C01); s_mf = 5'd12; step("R9 status old", 0, 0, 3'b000, 32'h0);
    s_mf = 5'd12; step("R9 status masked", 0, 0, 3'b000, 32'h0000_0C01);
    wr(5'd14, 32'h1234_5678); s_mf = 5'd14; step("R9 epc old", 0, 0, 3'b000, 32'h0);
    s_mf = 5'd14; step("R9 epc write", 0, 0, 3'b000, 32'h1234_5678);
    s_mf = 5'd5; step("R9 unmapped", 0, 0, 3'b000, 32'h0);
    // R2 overflow in stage 1
    set_exc(1, 5'd12, 32'h3000, 1'b0); s_mf = 5'd12;
    step("R2 overflow redirect", 1, H, 3'b110, 32'h0000_0C01);
    s_mf = 5'd13; step("R2 cause code 12", 0, 0, 3'b000, 32'h0000_0030);
    s_mf = 5'd14; step("R3 epc own pc", 0, 0, 3'b000, 32'h0000_3000);
    s_mf = 5'd12; step("R7 level set", 0, 0, 3'b000, 32'h0000_0C03);
    s_eret = 1'b1; s_mf = 5'd12; step("R7 return", 1, 32'h3000, 3'b110, 32'h0000_0C03);
    s_mf = 5'd12; step("R7 level cleared", 0, 0, 3'b000, 32'h0000_0C01);
    // R3 delay slot, fetch/load address fault
    set_exc(0, 5'd4, 32'h2008, 1'b1); step("R3 bd redirect", 1, H, 3'b111, 32'h0);
    s_mf = 5'd13; step("R3 bd cause", 0, 0, 3'b000, 32'h8000_0010);
    s_mf = 5'd14; step("R3 bd epc", 0, 0, 3'b000, 32'h0000_2004);
    // R11 nested, reserved opcode
    set_exc(2, 5'd10, 32'h5000, 1'b0); step("R11 nested redirect", 1, H, 3'b100, 32'h0);
    s_mf = 5'd13; step("R11 code updated bd held", 0, 0, 3'b000, 32'h8000_0028);
    s_mf = 5'd14; step("R11 epc held", 0, 0, 3'b000, 32'h0000_2004);
    // R5 blocked while level set
    s_irq = 2'b01; s_mf = 5'd13; step("R5 blocked by level", 0, 0, 3'b000, 32'h8000_0028);
    s_irq = 2'b01; s_mf = 5'd13; step("R8 pending seen", 0, 0, 3'b000, 32'h8000_0428);
    // R10 return beats exception and interrupt
    s_irq = 2'b01; s_eret = 1'b1; set_exc(1, 5'd12, 32'h3100, 1'b0); s_mf = 5'd12;
    step("R10 return first", 1, 32'h2004, 3'b110, 32'h0000_0C03);
    // R5 interrupt taken
    s_irq = 2'b01; s_pc[31:0] = 32'h6000; s_mf = 5'd12;
    step("R5 interrupt taken", 1, H, 3'b111, 32'h0000_0C01);
    s_mf = 5'd13; step("R5 interrupt code", 0, 0, 3'b000, 32'h0000_0400);
    s_mf = 5'd14; step("R5 interrupt epc", 0, 0, 3'b000, 32'h0000_6000);
    s_eret = 1'b1; s_mf = 5'd12; step("R7 return irq", 1, 32'h6000, 3'b110, 32'h0000_0C03);
    // R6 exception beats interrupt, store fault
    s_irq = 2'b10; set_exc(2, 5'd5, 32'h7000, 1'b0); s_mf = 5'd12;
    step("R6 exception over irq", 1, H, 3'b100, 32'h0000_0C01);
    s_irq = 2'b10; s_mf = 5'd13; step("R6 store code", 0, 0, 3'b000, 32'h0000_0814);
    s_mf = 5'd14; step("R6 epc", 0, 0, 3'b000, 32'h0000_7000);
    s_eret = 1'b1; step("R7 return store", 1, 32'h7000, 3'b110, 32'h0);
    // R4 oldest wins
    set_exc(1, 5'd12, 32'h0100, 1'b0); set_exc(2, 5'd10, 32'h0104, 1'b0);
    step("R4 oldest kill", 1, H, 3'b110, 32'h0);
    s_mf = 5'd13; step("R4 oldest code", 0, 0, 3'b000, 32'h0000_0030);
    s_mf = 5'd14; step("R4 oldest epc", 0, 0, 3'b000, 32'h0000_0100);
    s_eret = 1'b1; step("R7 return oldest", 1, 32'h0100, 3'b110, 32'h0);
    // R5 masking and global enable
    wr(5'd12, 32'h0000_0801); s_mf = 5'd12; step("R5 mask write", 0, 0, 3'b000, 32'h0000_0C01);
    s_irq = 2'b01; s_mf = 5'd12; step("R5 masked line", 0, 0, 3'b000, 32'h0000_0801);
    s_irq = 2'b10; s_pc[31:0] = 32'h8000; step("R5 unmasked line", 1, H, 3'b111, 32'h0);
    s_eret = 1'b1; step("R7 return masked", 1, 32'h8000, 3'b110, 32'h0);
    wr(5'd12, 32'h0000_0C00); step("R5 disable write", 0, 0, 3'b000, 32'h0);
    s_irq = 2'b11; s_mf = 5'd12; step("R5 global off", 0, 0, 3'b000, 32'h0000_0C00);
    s_irq = 2'b11; s_mf = 5'd13; step("R8 both pending", 0, 0, 3'b000, 32'h0000_0C00);
    s_mf = 5'd13; step("R8 one-cycle lag", 0, 0, 3'b000, 32'h0000_0C00);
    s_mf = 5'd13; step("R8 cleared", 0, 0, 3'b000, 32'h0);
    // R9 trap overrides write
    wr(5'd14, 32'hDEAD_0000); set_exc(0, 5'd12, 32'h0900, 1'b0);
    step("R9 trap with write", 1, H, 3'b111, 32'h0);
    s_mf = 5'd14; step("R9 trap wins epc", 0, 0, 3'b000, 32'h0000_0900);
    s_mf = 5'd12; step("R7 level only", 0, 0, 3'b000, 32'h0000_0C02);
    repeat (3) @(posedge clk_i);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 queue: %0d left, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule